// File: doc/BRIEF.md
# Priority Address Range Decoder

This block steers each memory access to one of several target regions. A small table is filled over a configuration port. Each table entry holds an inclusive lower and upper address bound and the number of the target that serves the range. An access carries an address, a size code and a read/write flag. The block checks whether the whole byte span of the access lies inside one entry. It answers with the target number and the offset of the access from that entry's lower bound. When no entry holds the span, it reports an error and drives no target.

Entries may overlap. The entry written last takes precedence, so a later entry can cut a hole in an earlier, wider one. A request is registered on entry and decoded from that register. The answer is registered again and marked by a one-cycle response strobe. A write that hits also produces byte enables for the selected target.

Top module: `addr_region_router`

## Requirements
- R1: After reset, rsp_valid is 0, every rsp_be bit is 0 and map_count is 0.
- R2: A request sampled at a rising edge with req_valid high gives rsp_valid high for exactly one cycle, after the second rising edge from that sample. rsp_valid is low in the cycle between.
- R3: An access hits an entry only when its address is at or above the entry's lower bound and its last byte (address + bytes − 1) is at or below the entry's upper bound.
- R4: When several entries contain the access, the entry written most recently is selected.
- R5: On a hit, rsp_hit is 1, rsp_err is 0, rsp_tgt is the entry's target and rsp_offset is the address minus the entry's lower bound.
- R6: On a miss, rsp_err is 1, rsp_hit is 0, rsp_tgt is 0, rsp_offset is 0 and all rsp_be bits are 0.
- R7: An access whose last byte would pass the top of the address space is a miss.
- R8: Size code 0 is one byte, 1 is two bytes and 2 is four bytes. Code 3 is reserved and always misses.
- R9: On a write hit, rsp_be[4*t +: 4] for the selected target t is 4'b0001, 4'b0011 or 4'b1111 for size codes 0, 1 and 2, and every other rsp_be bit is 0. A read drives all rsp_be bits to 0.
- R10: A configuration write whose upper bound is below its lower bound is dropped. It leaves map_count and the decode results unchanged.
- R11: Accepted entries fill table slots in order and raise map_count by one each. When map_count equals the table depth, further configuration writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Append an entry to the table |
| cfg_lo | input | ADDR_W | Inclusive lower bound of the new entry |
| cfg_hi | input | ADDR_W | Inclusive upper bound of the new entry |
| cfg_tgt | input | TGT_W | Target number of the new entry |
| map_count | output | CNT_W | Number of entries in use |
| req_valid | input | 1 | Access present |
| req_addr | input | ADDR_W | Access byte address |
| req_size | input | 2 | Size code (0 byte, 1 half, 2 word, 3 reserved) |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Result strobe |
| rsp_hit | output | 1 | An entry contains the access |
| rsp_err | output | 1 | Bad address: no entry contains the access |
| rsp_tgt | output | TGT_W | Selected target |
| rsp_offset | output | ADDR_W | Address minus the selected entry's lower bound |
| rsp_be | output | 4*N_TARGETS | Byte enables, four per target |

## Verification
The assertions assume that the table does not change while a request is being decoded, so cfg_wr is never high in the same cycle as a registered request. The bench separates configuration writes from accesses, and each access runs to its response before the next one starts. Addresses are chosen at random from the whole space and also clustered within a few bytes of each entry's bounds. This exercises both the straddling spans and the overlap precedence. Directed cases cover the top of the address space, a one-byte entry, a rejected entry and a full table.

// File: rtl/arr_pkg.sv
package arr_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    // number of bytes in the access, minus one
    function automatic logic [1:0] span_m1(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: span_m1 = 2'd0;
            SZ_HALF: span_m1 = 2'd1;
            default: span_m1 = 2'd3;
        endcase
    endfunction

    function automatic logic [3:0] lane_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: lane_mask = 4'b0001;
            SZ_HALF: lane_mask = 4'b0011;
            SZ_WORD: lane_mask = 4'b1111;
            default: lane_mask = 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/arr_table.sv
module arr_table #(
    parameter int ADDR_W    = 32,
    parameter int N_REGIONS = 8,
    parameter int TGT_W     = 3,
    localparam int IDX_W    = $clog2(N_REGIONS),
    localparam int CNT_W    = $clog2(N_REGIONS + 1)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cfg_wr,
    input  logic [ADDR_W-1:0]                    cfg_lo,
    input  logic [ADDR_W-1:0]                    cfg_hi,
    input  logic [TGT_W-1:0]                     cfg_tgt,
    output logic [N_REGIONS-1:0][ADDR_W-1:0]     tbl_lo,
    output logic [N_REGIONS-1:0][ADDR_W-1:0]     tbl_hi,
    output logic [N_REGIONS-1:0][TGT_W-1:0]      tbl_tgt,
    output logic [N_REGIONS-1:0]                 tbl_vld,
    output logic [CNT_W-1:0]                     count
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(N_REGIONS);

    typedef struct packed {
        logic [N_REGIONS-1:0][ADDR_W-1:0] lo;
        logic [N_REGIONS-1:0][ADDR_W-1:0] hi;
        logic [N_REGIONS-1:0][TGT_W-1:0]  tgt;
        logic [N_REGIONS-1:0]             vld;
        logic [CNT_W-1:0]                 cnt;
    } tbl_st_t;

    tbl_st_t st_d, st_q;
    logic [IDX_W-1:0] slot;
    logic             accept;

    always_comb begin
        st_d   = st_q;
        slot   = st_q.cnt[IDX_W-1:0];
        accept = cfg_wr && (cfg_hi >= cfg_lo) && (st_q.cnt < FULL);
        if (accept) begin
            st_d.lo[slot]  = cfg_lo;
            st_d.hi[slot]  = cfg_hi;
            st_d.tgt[slot] = cfg_tgt;
            st_d.vld[slot] = 1'b1;
            st_d.cnt       = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tbl_lo  = st_q.lo;
    assign tbl_hi  = st_q.hi;
    assign tbl_tgt = st_q.tgt;
    assign tbl_vld = st_q.vld;
    assign count   = st_q.cnt;

    a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL);

    a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (count == $past(count)) || (count == $past(count) + 1'b1));

    a_r11_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL) |=> (count == FULL));

    a_r10_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (cfg_hi < cfg_lo)) |=> $stable(count));

endmodule

// File: rtl/arr_match.sv
module arr_match
    import arr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int N_REGIONS = 8,
    parameter int TGT_W     = 3,
    localparam int IDX_W    = $clog2(N_REGIONS)
) (
    input  logic [N_REGIONS-1:0][ADDR_W-1:0] tbl_lo,
    input  logic [N_REGIONS-1:0][ADDR_W-1:0] tbl_hi,
    input  logic [N_REGIONS-1:0][TGT_W-1:0]  tbl_tgt,
    input  logic [N_REGIONS-1:0]             tbl_vld,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [1:0]                       size,
    output logic                             hit,
    output logic [IDX_W-1:0]                 sel,
    output logic [TGT_W-1:0]                 tgt,
    output logic [ADDR_W-1:0]                offset
);

    logic [ADDR_W:0]          span_end;
    logic                     wraps;
    logic                     rsvd;
    logic [N_REGIONS-1:0]     contain;

    assign span_end = {1'b0, addr} + {{(ADDR_W-1){1'b0}}, span_m1(size)};
    assign wraps    = span_end[ADDR_W];
    assign rsvd     = (size == SZ_RSVD);

    for (genvar i = 0; i < N_REGIONS; i++) begin : g_cmp
        assign contain[i] = tbl_vld[i] && !wraps && !rsvd
                         && (addr >= tbl_lo[i])
                         && (span_end[ADDR_W-1:0] <= tbl_hi[i]);
    end

    // higher slot was written later and takes precedence
    always_comb begin
        sel = '0;
        for (int i = 0; i < N_REGIONS; i++) begin
            if (contain[i]) sel = IDX_W'(i);
        end
    end

    assign hit    = |contain;
    assign tgt    = hit ? tbl_tgt[sel] : '0;
    assign offset = hit ? (addr - tbl_lo[sel]) : '0;

endmodule

// File: rtl/addr_region_router.sv
module addr_region_router
    import arr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int N_REGIONS = 8,
    parameter int N_TARGETS = 8,
    localparam int TGT_W    = $clog2(N_TARGETS),
    localparam int IDX_W    = $clog2(N_REGIONS),
    localparam int CNT_W    = $clog2(N_REGIONS + 1),
    localparam int BE_W     = 4 * N_TARGETS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_lo,
    input  logic [ADDR_W-1:0] cfg_hi,
    input  logic [TGT_W-1:0]  cfg_tgt,
    output logic [CNT_W-1:0]  map_count,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_err,
    output logic [TGT_W-1:0]  rsp_tgt,
    output logic [ADDR_W-1:0] rsp_offset,
    output logic [BE_W-1:0]   rsp_be
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        size;
        logic              write;
    } req_st_t;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              err;
        logic [TGT_W-1:0]  tgt;
        logic [ADDR_W-1:0] offset;
        logic [BE_W-1:0]   be;
    } rsp_st_t;

    req_st_t rq_d, rq_q;
    rsp_st_t rs_d, rs_q;

    logic [N_REGIONS-1:0][ADDR_W-1:0] tbl_lo;
    logic [N_REGIONS-1:0][ADDR_W-1:0] tbl_hi;
    logic [N_REGIONS-1:0][TGT_W-1:0]  tbl_tgt;
    logic [N_REGIONS-1:0]             tbl_vld;

    logic              m_hit;
    logic [IDX_W-1:0]  m_sel;
    logic [TGT_W-1:0]  m_tgt;
    logic [ADDR_W-1:0] m_offset;

    arr_table #(
        .ADDR_W    (ADDR_W),
        .N_REGIONS (N_REGIONS),
        .TGT_W     (TGT_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (cfg_wr),
        .cfg_lo  (cfg_lo),
        .cfg_hi  (cfg_hi),
        .cfg_tgt (cfg_tgt),
        .tbl_lo  (tbl_lo),
        .tbl_hi  (tbl_hi),
        .tbl_tgt (tbl_tgt),
        .tbl_vld (tbl_vld),
        .count   (map_count)
    );

    arr_match #(
        .ADDR_W    (ADDR_W),
        .N_REGIONS (N_REGIONS),
        .TGT_W     (TGT_W)
    ) u_match (
        .tbl_lo  (tbl_lo),
        .tbl_hi  (tbl_hi),
        .tbl_tgt (tbl_tgt),
        .tbl_vld (tbl_vld),
        .addr    (rq_q.addr),
        .size    (rq_q.size),
        .hit     (m_hit),
        .sel     (m_sel),
        .tgt     (m_tgt),
        .offset  (m_offset)
    );

    always_comb begin
        rq_d.valid = req_valid;
        rq_d.addr  = req_addr;
        rq_d.size  = req_size;
        rq_d.write = req_write;

        rs_d        = '0;
        rs_d.valid  = rq_q.valid;
        if (rq_q.valid) begin
            rs_d.hit    = m_hit;
            rs_d.err    = !m_hit;
            rs_d.tgt    = m_tgt;
            rs_d.offset = m_offset;
            for (int t = 0; t < N_TARGETS; t++) begin
                if (m_hit && rq_q.write && (m_tgt == TGT_W'(t)))
                    rs_d.be[4*t +: 4] = lane_mask(rq_q.size);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_q <= '0;
            rs_q <= '0;
        end else begin
            rq_q <= rq_d;
            rs_q <= rs_d;
        end
    end

    assign rsp_valid  = rs_q.valid;
    assign rsp_hit    = rs_q.hit;
    assign rsp_err    = rs_q.err;
    assign rsp_tgt    = rs_q.tgt;
    assign rsp_offset = rs_q.offset;
    assign rsp_be     = rs_q.be;

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ##2 rsp_valid);

    a_r5_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit ^ rsp_err));

    a_r6_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_be == '0 && rsp_offset == '0 && rsp_tgt == '0));

    a_r9_be_count: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(rsp_be) == 0) || ($countones(rsp_be) == 1)
        || ($countones(rsp_be) == 2) || ($countones(rsp_be) == 4));

    a_r9_idle_be: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_be == '0));

    a_r3_contained: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_q.valid && m_hit) |-> (tbl_vld[m_sel] && rq_q.addr >= tbl_lo[m_sel]
                                   && rq_q.addr <= tbl_hi[m_sel]));

endmodule

// File: tb/sim_addr_region_router.sv
`timescale 1ns/1ps
module sim_addr_region_router;

    localparam int AW = 32;
    localparam int NR = 8;
    localparam int NT = 8;
    localparam int TW = 3;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [AW-1:0] cfg_lo = '0;
    logic [AW-1:0] cfg_hi = '0;
    logic [TW-1:0] cfg_tgt = '0;
    logic [CW-1:0] map_count;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic          req_write = 1'b0;
    logic          rsp_valid, rsp_hit, rsp_err;
    logic [TW-1:0] rsp_tgt;
    logic [AW-1:0] rsp_offset;
    logic [4*NT-1:0] rsp_be;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [AW-1:0] m_lo [NR];
    logic [AW-1:0] m_hi [NR];
    int            m_tgt[NR];
    int            m_cnt = 0;

    always #2.5 clk = ~clk;

    addr_region_router #(.ADDR_W(AW), .N_REGIONS(NR), .N_TARGETS(NT)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_tgt(cfg_tgt),
        .map_count(map_count),
        .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
        .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
        .rsp_tgt(rsp_tgt), .rsp_offset(rsp_offset), .rsp_be(rsp_be)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    task automatic add_entry(input logic [AW-1:0] lo, input logic [AW-1:0] hi, input int t);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_lo = lo; cfg_hi = hi; cfg_tgt = TW'(t);
        @(negedge clk);
        cfg_wr = 1'b0;
        if (hi >= lo && m_cnt < NR) begin
            m_lo[m_cnt] = lo; m_hi[m_cnt] = hi; m_tgt[m_cnt] = t;
            m_cnt++;
        end
        chk("R10/R11 map_count", map_count, m_cnt);
    endtask

    task automatic access(input logic [AW-1:0] a, input logic [1:0] sz,
                          input logic wr, input string tag);
        longint last;
        int     idx;
        longint e_off, e_be;
        int     e_tgt;
        bit     e_hit;
        last  = longint'(a) + nbytes(sz) - 1;
        idx   = -1;
        if (sz != 2'd3 && last <= 64'hFFFF_FFFF) begin
            for (int i = m_cnt - 1; i >= 0 && idx < 0; i--)
                if (a >= m_lo[i] && last <= longint'(m_hi[i])) idx = i;
        end
        e_hit = (idx >= 0);
        e_tgt = e_hit ? m_tgt[idx] : 0;
        e_off = e_hit ? longint'(a - m_lo[idx]) : 0;
        e_be  = 0;
        if (e_hit && wr)
            e_be = longint'((sz == 2'd0) ? 1 : (sz == 2'd1) ? 3 : 15) << (4 * e_tgt);

        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        chk({"R2 gap ", tag}, rsp_valid, 0);
        @(negedge clk);
        chk({"R2 strobe ", tag}, rsp_valid, 1);
        chk({"R5/R6 hit ", tag}, rsp_hit, e_hit);
        chk({"R6 err ", tag}, rsp_err, !e_hit);
        chk({"R4/R5 tgt ", tag}, rsp_tgt, e_tgt);
        chk({"R5 offset ", tag}, rsp_offset, e_off);
        chk({"R9 be ", tag}, rsp_be, e_be);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        repeat (3) @(negedge clk);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 rsp_be", rsp_be, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 map_count", map_count, 0);

        access(32'h0000_1000, 2'd2, 1'b1, "R6 empty table");

        add_entry(32'h0000_1000, 32'h0000_1FFF, 1);
        add_entry(32'h0000_1800, 32'h0000_18FF, 2);
        add_entry(32'hFFFF_FF00, 32'hFFFF_FFFF, 3);
        add_entry(32'h0000_5000, 32'h0000_4000, 6);     // R10 rejected
        access(32'h0000_4800, 2'd0, 1'b0, "R10 dropped entry");
        add_entry(32'h0000_2000, 32'h0000_2000, 4);

        access(32'h0000_1000, 2'd2, 1'b1, "R3 low edge word");
        access(32'h0000_1FFC, 2'd2, 1'b1, "R3 top edge word");
        access(32'h0000_1FFD, 2'd2, 1'b0, "R3 straddle top");
        access(32'h0000_0FFF, 2'd1, 1'b1, "R3 straddle bottom");
        access(32'h0000_1880, 2'd1, 1'b1, "R4 newer overlap");
        access(32'h0000_18FF, 2'd1, 1'b1, "R4 cross into older");
        access(32'h0000_2000, 2'd0, 1'b1, "R8 one byte entry");
        access(32'h0000_2000, 2'd1, 1'b1, "R8 half too big");
        access(32'h0000_1100, 2'd3, 1'b1, "R8 reserved size");
        access(32'hFFFF_FFFF, 2'd0, 1'b1, "R7 top byte");
        access(32'hFFFF_FFFE, 2'd2, 1'b1, "R7 wrap word");
        access(32'hFFFF_FFFC, 2'd2, 1'b0, "R9 read top word");

        while (m_cnt < NR) begin
            logic [AW-1:0] lo;
            lo = $urandom & 32'h0FFF_FFF0;
            add_entry(lo, lo + ($urandom % 32'h400), int'($urandom % NT));
        end
        add_entry(32'h0000_3000, 32'h0000_3FFF, 5);     // R11 full, ignored
        access(32'h0000_3000, 2'd0, 1'b1, "R11 ignored when full");

        for (int n = 0; n < 1500; n++) begin
            logic [AW-1:0] a;
            int e;
            if ($urandom % 4 == 0) a = $urandom;
            else begin
                e = int'($urandom % NR);
                a = (($urandom % 2) != 0) ? m_lo[e] : m_hi[e];
                a = a + ($urandom % 9) - 4;
            end
            access(a, 2'($urandom), 1'($urandom), "R3/R4/R9 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule